// File: doc/BRIEF.md
# USART Baud Rate Clock Generator

This block produces the bit-rate timing enables for a serial transceiver. A 12-bit divisor, loaded through two byte-wide write strobes, sets the reload value of a down-counter clocked by the system clock. Each time the counter reaches zero it emits a one-cycle base tick and reloads itself, so the base tick rate is fclk/(divisor+1). Writing the low byte of the divisor reloads the counter at once, without waiting for zero.

The undivided base tick goes to the receiver's bit recovery logic as `rx_tick`. A prescaler derives `tx_tick` from it. The ratio depends on a mode decoded from three controls: 16 in normal asynchronous mode, 8 in double-speed asynchronous mode, and 2 in synchronous master mode. In synchronous master mode a toggle flop drives the divided clock out on the external clock pin. In synchronous slave mode both ticks come from the external clock pin instead, after a two-flop synchronizer and an edge detector whose active edge a polarity control selects. All outputs are single-cycle enables in the system clock domain.

Top module: `baud_clkgen`

## Requirements
- R1: While `rst_n` is low, `rx_tick`, `tx_tick` and `xck_out` are all 0.
- R2: In asynchronous mode (`sync_mode`=0) with divisor D, where D is {high nibble, low byte}, `rx_tick` pulses for one cycle every D+1 cycles.
- R3: A high-nibble write (`wr_hi`, data bits 3:0) does not reload the counter. The running count finishes with the old value, and the new value takes effect at the next natural reload.
- R4: A low-byte write (`wr_lo`) with resulting divisor V reloads the counter on the clock edge that samples it. The next `rx_tick` appears V cycles after that edge, and further ticks follow every V+1 cycles.
- R5: When a low-byte write falls in a cycle where the counter is at zero, that cycle's `rx_tick` is still produced, and the next ticks follow the newly written divisor.
- R6: In normal asynchronous mode (`sync_mode`=0, `dbl_speed`=0), `tx_tick` is asserted together with every 16th `rx_tick`, counted from the last low-byte write. `tx_tick` is never high without `rx_tick`.
- R7: In double-speed asynchronous mode (`sync_mode`=0, `dbl_speed`=1), `tx_tick` is asserted together with every 8th `rx_tick` after the last low-byte write.
- R8: In synchronous master mode (`sync_mode`=1, `pin_dir_out`=1), `xck_oe` is 1, `tx_tick` is asserted with every 2nd `rx_tick`, and `xck_out` inverts on the clock edge after each `rx_tick`. In every other mode `xck_out` holds its value.
- R9: `dbl_speed` has no effect in synchronous mode. Master mode divides by 2 with `dbl_speed` at 0 or 1.
- R10: In synchronous slave mode (`sync_mode`=1, `pin_dir_out`=0) with `clk_pol`=0, `xck_oe` is 0. A rising edge of `xck_in` (set up before clock edge n) gives a one-cycle pulse on both `rx_tick` and `tx_tick` in the cycle after edge n+1. A falling edge gives no tick.
- R11: In synchronous slave mode with `clk_pol`=1, the falling edge of `xck_in` produces the tick with the same latency, and the rising edge gives none.
- R12: A divisor of 0 yields `rx_tick` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_lo | input | 1 | Write strobe for the divisor low byte; forces a counter reload |
| wr_hi | input | 1 | Write strobe for the divisor high nibble |
| wr_data | input | 8 | Write data for both strobes (high nibble uses bits 3:0) |
| sync_mode | input | 1 | 1 selects synchronous operation |
| dbl_speed | input | 1 | Asynchronous double-speed select |
| pin_dir_out | input | 1 | In synchronous mode, 1 drives the clock pin (master), 0 samples it (slave) |
| clk_pol | input | 1 | Slave active edge: 0 rising, 1 falling |
| xck_in | input | 1 | External clock pin input |
| xck_out | output | 1 | External clock pin output value |
| xck_oe | output | 1 | External clock pin output enable |
| tx_tick | output | 1 | Transmitter clock enable |
| rx_tick | output | 1 | Receiver base clock enable |

## Verification
The forced reload from a low-byte write and the natural reload at zero can land in the same cycle. The bench predicts the exact cycle of a zero-count tick from the previous write and issues a new low-byte write in that cycle. It then expects the tick to be present in that cycle and every later tick to be spaced by the new divisor, with the transmit prescaler realigned to the write. A scoreboard holds the expected tick cycles and transmit flags for each mode and compares them against every observed receive tick.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // Largest transmit division ratio across all modes.
  localparam int unsigned MAX_RATIO = 16;
  localparam int unsigned PRE_W_DEF = $clog2(MAX_RATIO);

  typedef enum logic [1:0] {
    MD_ASYNC_X16 = 2'd0,
    MD_ASYNC_X8  = 2'd1,
    MD_SYNC_MST  = 2'd2,
    MD_SYNC_SLV  = 2'd3
  } clk_mode_e;

  // Double speed only matters when the link is asynchronous.
  function automatic clk_mode_e decode_mode(input logic sync_sel,
                                            input logic dbl,
                                            input logic drive);
    if (sync_sel) return drive ? MD_SYNC_MST : MD_SYNC_SLV;
    return dbl ? MD_ASYNC_X8 : MD_ASYNC_X16;
  endfunction

  function automatic int unsigned tx_ratio(input clk_mode_e m);
    case (m)
      MD_ASYNC_X16: return MAX_RATIO;
      MD_ASYNC_X8:  return MAX_RATIO / 2;
      MD_SYNC_MST:  return 2;
      default:      return 1;
    endcase
  endfunction

endpackage

// File: rtl/baud_divcnt.sv
module baud_divcnt #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned LO_W  = 8,
  parameter logic [DIV_W-1:0] RST_DIV = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [LO_W-1:0] wr_data,
  output logic            base_tick
);

  localparam int unsigned HI_W = DIV_W - LO_W;
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             run_q;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign base_tick = run_q & cnt_zero;

  // Divisor register: the two halves are written independently.
  always_comb begin
    div_d = div_q;
    if (wr_hi) div_d[DIV_W-1:LO_W] = wr_data[HI_W-1:0];
    if (wr_lo) div_d[LO_W-1:0]     = wr_data;
  end

  // A low write wins over the natural reload; a natural reload uses the
  // divisor held before this edge.
  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo)      cnt_d = div_d;
    else if (run_q) cnt_d = cnt_zero ? div_q : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= RST_DIV;
      cnt_q <= RST_DIV;
      run_q <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      run_q <= 1'b1;
    end
  end

endmodule

// File: rtl/baud_txdiv.sv
module baud_txdiv
  import baud_pkg::*;
#(
  parameter int unsigned PRE_W = PRE_W_DEF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      base_tick,
  input  logic      realign,
  input  clk_mode_e mode,
  output logic      tx_base,
  output logic      pin_q
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] term;
  logic             last;
  logic             pin_d;
  logic             toggle_en;

  // Ratio minus one; >= keeps a shrinking ratio from overrunning.
  assign term    = PRE_W'(tx_ratio(mode) - 1);
  assign last    = (pre_q >= term);
  assign tx_base = base_tick & last;

  assign toggle_en = base_tick & (mode == MD_SYNC_MST);

  always_comb begin
    pre_d = pre_q;
    if (realign)        pre_d = '0;
    else if (base_tick) pre_d = last ? '0 : (pre_q + PRE_W'(1));
  end

  always_comb begin
    pin_d = pin_q;
    if (toggle_en) pin_d = ~pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      pin_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      pin_q <= pin_d;
    end
  end

endmodule

// File: rtl/xck_edge.sv
module xck_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic fall_sel,
  output logic pin_tick
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic                   synced;
  logic                   rise;
  logic                   fall;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      assign sync_d = pin_in;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_in};
    end
  endgenerate

  assign synced   = sync_q[SYNC_STAGES-1];
  assign rise     = synced & ~prev_q;
  assign fall     = ~synced & prev_q;
  assign pin_tick = fall_sel ? fall : rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= synced;
    end
  end

endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W       = 12,
  parameter int unsigned LO_W        = 8,
  parameter int unsigned RST_DIV     = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [LO_W-1:0] wr_data,
  input  logic            sync_mode,
  input  logic            dbl_speed,
  input  logic            pin_dir_out,
  input  logic            clk_pol,
  input  logic            xck_in,
  output logic            xck_out,
  output logic            xck_oe,
  output logic            tx_tick,
  output logic            rx_tick
);

  clk_mode_e mode;
  logic      base_tick;
  logic      tx_base;
  logic      pin_tick;
  logic      pin_q;
  logic      slave;

  assign mode  = decode_mode(sync_mode, dbl_speed, pin_dir_out);
  assign slave = (mode == MD_SYNC_SLV);

  baud_divcnt #(
    .DIV_W   (DIV_W),
    .LO_W    (LO_W),
    .RST_DIV (DIV_W'(RST_DIV))
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .base_tick (base_tick)
  );

  baud_txdiv #(
    .PRE_W (PRE_W_DEF)
  ) u_txdiv (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .realign   (wr_lo),
    .mode      (mode),
    .tx_base   (tx_base),
    .pin_q     (pin_q)
  );

  xck_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (xck_in),
    .fall_sel (clk_pol),
    .pin_tick (pin_tick)
  );

  assign rx_tick = slave ? pin_tick : base_tick;
  assign tx_tick = slave ? pin_tick : tx_base;
  assign xck_oe  = (mode == MD_SYNC_MST);
  assign xck_out = pin_q;

endmodule

// File: rtl/baud_clkgen_chk.sv
module baud_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_mode,
  input logic pin_dir_out,
  input logic clk_pol,
  input logic xck_oe,
  input logic xck_out,
  input logic tx_tick,
  input logic rx_tick
);

  logic master;
  logic slave;

  assign master = sync_mode & pin_dir_out;
  assign slave  = sync_mode & ~pin_dir_out;

  AST_TX_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |-> rx_tick); // R6

  AST_MASTER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> xck_oe); // R8

  AST_SLAVE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !xck_oe); // R10

  AST_MASTER_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (master && rx_tick) |=> (xck_out != $past(xck_out))); // R8

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> $stable(xck_out)); // R8

  AST_SLAVE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && rx_tick) |=> !(slave && $stable(clk_pol) && rx_tick)); // R10

endmodule

bind baud_clkgen baud_clkgen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_mode   (sync_mode),
  .pin_dir_out (pin_dir_out),
  .clk_pol     (clk_pol),
  .xck_oe      (xck_oe),
  .xck_out     (xck_out),
  .tx_tick     (tx_tick),
  .rx_tick     (rx_tick)
);

// File: tb/baud_clkgen_bench.sv
`timescale 1ns/1ps
module baud_clkgen_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_lo, wr_hi;
  logic [7:0] wr_data;
  logic       sync_mode, dbl_speed, pin_dir_out, clk_pol, xck_in;
  logic       xck_out, xck_oe, tx_tick, rx_tick;

  always #10 clk = ~clk;

  baud_clkgen u_baud_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_lo       (wr_lo),
    .wr_hi       (wr_hi),
    .wr_data     (wr_data),
    .sync_mode   (sync_mode),
    .dbl_speed   (dbl_speed),
    .pin_dir_out (pin_dir_out),
    .clk_pol     (clk_pol),
    .xck_in      (xck_in),
    .xck_out     (xck_out),
    .xck_oe      (xck_oe),
    .tx_tick     (tx_tick),
    .rx_tick     (rx_tick)
  );

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_cyc[$];
  bit    exp_tx[$];
  bit    armed = 1'b0;
  bit    chk_pin = 1'b0;
  bit    have_last = 1'b0;
  logic  last_pin;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: every receive tick while armed must match the next expectation.
  always @(negedge clk) begin
    if (armed) begin
      if (tx_tick && !rx_tick) check(1'b0, "R6", "tx without rx", 1, 0);
      if (rx_tick) begin
        if (exp_cyc.size() == 0) begin
          check(1'b0, cur_req, "unexpected tick at cycle", cyc, -1);
        end else begin
          int ec;
          bit et;
          ec = exp_cyc.pop_front();
          et = exp_tx.pop_front();
          check(cyc == ec, cur_req, "tick cycle", cyc, ec);
          check(tx_tick == et, cur_req, "tx flag", int'(tx_tick), int'(et));
        end
        if (chk_pin) begin
          if (have_last)
            check(xck_out != last_pin, "R8", "pin toggle", int'(xck_out), int'(!last_pin));
          last_pin  = xck_out;
          have_last = 1'b1;
        end
      end
    end
  end

  // Driver helpers; writes are issued between edges.
  task automatic push(input int e, input int v, input int n, input int k0, input int k1);
    for (int k = k0; k <= k1; k++) begin
      exp_cyc.push_back(e + v + k * (v + 1));
      exp_tx.push_back(((k + 1) % n) == 0);
    end
  endtask

  task automatic write_lo(input logic [7:0] d, output int e);
    wr_lo   = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    e         = cyc;
    wr_lo     = 1'b0;
    armed     = 1'b1;
    have_last = 1'b0;
  endtask

  task automatic write_hi(input logic [7:0] d);
    wr_hi   = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_hi = 1'b0;
  endtask

  task automatic wait_cyc(input int c);
    do @(negedge clk); while (cyc < c);
  endtask

  task automatic drain();
    while (exp_cyc.size() != 0) begin
      @(negedge clk);
      #1;
    end
    armed   = 1'b0;
    chk_pin = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cyc, 0);
    finish_run();
  end

  initial begin
    int e, e2, c;
    rst_n = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0; wr_data = '0;
    sync_mode = 1'b0; dbl_speed = 1'b0; pin_dir_out = 1'b0; clk_pol = 1'b0; xck_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    check(rx_tick == 1'b0, "R1", "rx_tick in reset", int'(rx_tick), 0);
    check(tx_tick == 1'b0, "R1", "tx_tick in reset", int'(tx_tick), 0);
    check(xck_out == 1'b0, "R1", "xck_out in reset", int'(xck_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 with R6: divisor 0 ticks every cycle, tx on every 16th
    cur_req = "R12/R6";
    write_hi(8'h00);
    write_lo(8'h00, e);
    push(e, 0, 16, 0, 31);
    drain();

    // R2, R4, R6: divisor 5
    cur_req = "R2/R4/R6";
    @(negedge clk);
    write_lo(8'h05, e);
    push(e, 5, 16, 0, 33);
    drain();

    // R2, R7: divisor 0x102 using both halves, double speed
    cur_req = "R2/R7";
    @(negedge clk);
    dbl_speed = 1'b1;
    write_hi(8'h01);
    write_lo(8'h02, e);
    push(e, 258, 8, 0, 8);
    drain();

    // R3: high write lands on a reload edge, old count finishes first
    cur_req = "R3";
    @(negedge clk);
    dbl_speed = 1'b0;
    write_hi(8'h00);
    write_lo(8'h04, e);
    push(e, 4, 16, 0, 3);
    exp_cyc.push_back(e + 19 + 261);
    exp_tx.push_back(1'b0);
    wait_cyc(e + 14);
    write_hi(8'h01);
    drain();

    // R5: low write in the same cycle as a zero-count tick
    cur_req = "R5/R4";
    @(negedge clk);
    write_hi(8'h00);
    write_lo(8'h03, e);
    push(e, 3, 16, 0, 2);
    wait_cyc(e + 11);
    #1;
    check(rx_tick == 1'b1, "R5", "tick in write cycle", int'(rx_tick), 1);
    write_lo(8'h06, e2);
    push(e2, 6, 16, 0, 3);
    drain();

    // R8: synchronous master, divide by 2, pin toggles
    cur_req = "R8";
    @(negedge clk);
    sync_mode = 1'b1; pin_dir_out = 1'b1; dbl_speed = 1'b0;
    #1;
    check(xck_oe == 1'b1, "R8", "xck_oe in master", int'(xck_oe), 1);
    write_lo(8'h02, e);
    chk_pin = 1'b1;
    push(e, 2, 2, 0, 7);
    drain();

    // R9: double speed ignored in master mode
    cur_req = "R9";
    @(negedge clk);
    dbl_speed = 1'b1;
    write_lo(8'h00, e);
    chk_pin = 1'b1;
    push(e, 0, 2, 0, 7);
    drain();

    // R10: slave, rising edge active
    cur_req = "R10";
    @(negedge clk);
    pin_dir_out = 1'b0; clk_pol = 1'b0; dbl_speed = 1'b0;
    #1;
    check(xck_oe == 1'b0, "R10", "xck_oe in slave", int'(xck_oe), 0);
    armed = 1'b1;
    @(negedge clk);
    xck_in = 1'b1; c = cyc;
    exp_cyc.push_back(c + 2); exp_tx.push_back(1'b1);
    repeat (6) @(negedge clk);
    xck_in = 1'b0;
    repeat (6) @(negedge clk);
    xck_in = 1'b1; c = cyc;
    exp_cyc.push_back(c + 2); exp_tx.push_back(1'b1);
    repeat (6) @(negedge clk);
    check(exp_cyc.size() == 0, "R10", "pending slave ticks", exp_cyc.size(), 0);
    drain();

    // R11: slave, falling edge active (pin currently high)
    cur_req = "R11";
    @(negedge clk);
    clk_pol = 1'b1;
    armed = 1'b1;
    @(negedge clk);
    xck_in = 1'b0; c = cyc;
    exp_cyc.push_back(c + 2); exp_tx.push_back(1'b1);
    repeat (6) @(negedge clk);
    xck_in = 1'b1;
    repeat (6) @(negedge clk);
    xck_in = 1'b0; c = cyc;
    exp_cyc.push_back(c + 2); exp_tx.push_back(1'b1);
    repeat (6) @(negedge clk);
    check(exp_cyc.size() == 0, "R11", "pending slave ticks", exp_cyc.size(), 0);
    drain();

    finish_run();
  end

endmodule